// File: doc/BRIEF.md
# Byte-serial instruction field parser

This block takes a variable-length instruction encoding one byte at a time and splits each instruction into its fields. A byte moves on every cycle where `in_valid` and `in_ready` are both high. The parser first collects override prefixes and then the opcode. After that it reads an optional mode byte and an optional scale/index/base byte, then a displacement of 0, 1, 2 or 4 bytes and an immediate of 0, 1, 2 or 4 bytes. When the last byte of an instruction has been taken, it presents one record for one cycle.

Whether a mode byte follows the opcode, and how large the immediate is, comes from a small opcode table. The table is supplied on input ports as match/mask pairs. The parser does not look up the presence of the scale/index/base byte or the displacement length in any table. It works them out as the bytes arrive, from the mode byte, the base field and the address size in force for the current instruction. Default operand and address sizes are parameters. An override prefix flips the matching size for one instruction only.

Top module: `instr_field_parser`

## Requirements
- R1: While reset is active and after it is released, `rec_valid` is low, and `in_ready` equals the inverse of `stall`.
- R2: In the lead position, byte 0x66 flips the operand size and byte 0x67 flips the address size relative to their parameter defaults. Repeating a prefix counts the same as giving it once. The flip applies only to the instruction that follows, and the next instruction starts again from the defaults. A prefix never produces a record.
- R3: When the opcode takes a mode byte, the record gives bits 7:6 as `rec_mod`, bits 5:3 as `rec_reg` and bits 2:0 as `rec_rm`. Without a mode byte all three are zero, except that `rec_reg` is still taken from the opcode in the short form of R9.
- R4: A scale/index/base byte follows the mode byte exactly when the address size is 32 bits, mod is not 11 and r/m is 100. Its bits 7:6, 5:3 and 2:0 are reported as scale, index and base. When this byte is absent, those fields read zero.
- R5: With 16-bit addressing, the displacement length is 1 byte for mod 01, 2 bytes for mod 10, 2 bytes for mod 00 with r/m 110, and 0 bytes otherwise, including mod 11.
- R6: With 32-bit addressing, the displacement length is 1 byte for mod 01 and 4 bytes for mod 10. For mod 00 it is 4 bytes when r/m is 101, or when a scale/index/base byte is present with base 101. In all other cases it is 0 bytes.
- R7: Displacement and immediate bytes are assembled least significant byte first. For example, bytes 34 12 give 0x1234. Bytes above the field length read zero.
- R8: Table entry k matches when the opcode and the entry's match value are equal in every bit set in the entry's mask. The lowest-numbered matching entry wins. Its 2-bit immediate code gives the immediate size: 00 is none, 01 is 1 byte, 10 is 2 bytes, and 11 is the operand size (2 or 4 bytes). An opcode that matches no entry has no mode byte and no immediate.
- R9: An opcode whose upper five bits are 10111 has no mode byte and an immediate of the operand size, and `rec_reg` is the opcode's low three bits. This holds whatever the table says.
- R10: `rec_valid` is high for exactly one cycle per instruction, in the cycle after the instruction's final byte is accepted. Every instruction contains at least its opcode byte.
- R11: While `stall` is high, `in_ready` is low, no byte is taken and the parse state is kept. The records that follow are exactly those of an unstalled stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Back-pressure request; forces `in_ready` low |
| in_valid | input | 1 | `in_byte` holds a stream byte |
| in_byte | input | 8 | Instruction stream byte |
| in_ready | output | 1 | Parser accepts a byte this cycle |
| tbl_match | input | NUM_ENT*8 (64) | Opcode match value per entry, entry k in bits 8k+7:8k |
| tbl_mask | input | NUM_ENT*8 (64) | Compare mask per entry |
| tbl_modrm | input | NUM_ENT (8) | Entry k: opcode takes a mode byte |
| tbl_imm | input | NUM_ENT*2 (16) | Entry k immediate code in bits 2k+1:2k |
| rec_valid | output | 1 | One-cycle record strobe |
| rec_opnd32 | output | 1 | Operand size of the record is 32 bits |
| rec_addr32 | output | 1 | Address size of the record is 32 bits |
| rec_opcode | output | 8 | Opcode byte |
| rec_has_modrm | output | 1 | A mode byte was present |
| rec_mod | output | 2 | Mode byte bits 7:6 |
| rec_reg | output | 3 | Mode byte bits 5:3, or opcode bits 2:0 in the short form |
| rec_rm | output | 3 | Mode byte bits 2:0 |
| rec_has_sib | output | 1 | A scale/index/base byte was present |
| rec_scale | output | 2 | Scale field |
| rec_index | output | 3 | Index field |
| rec_base | output | 3 | Base field |
| rec_disp_len | output | 3 | Displacement length in bytes |
| rec_disp | output | 32 | Displacement, zero-extended |
| rec_imm_len | output | 3 | Immediate length in bytes |
| rec_imm | output | 32 | Immediate, zero-extended |

## Verification
Two things can happen in the same clock cycle. The record of one instruction can be presented while the first byte of the next instruction, often an override prefix, is being accepted. Also, the last displacement or immediate byte is merged into the record in the same cycle that the working fields are cleared. The bench provokes both by streaming instructions back to back with `in_valid` held high, so that prefixed instructions directly follow ones that end in multi-byte fields. A behavioural model predicts, on every clock, whether a record is due and what it must contain. Sizes leaking from one instruction into the next, or a final byte being dropped, therefore show up as field mismatches.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

  localparam int FIELD_BYTES = 4;
  localparam int FIELD_W     = FIELD_BYTES * 8;
  localparam int POS_W       = $clog2(FIELD_BYTES);

  localparam logic [7:0] PFX_OPND = 8'h66;
  localparam logic [7:0] PFX_ADDR = 8'h67;

  localparam logic [1:0] IMC_NONE = 2'b00;
  localparam logic [1:0] IMC_ONE  = 2'b01;
  localparam logic [1:0] IMC_TWO  = 2'b10;
  localparam logic [1:0] IMC_OPSZ = 2'b11;

  typedef enum logic [2:0] {
    ST_LEAD = 3'd0,
    ST_MODE = 3'd1,
    ST_SIB  = 3'd2,
    ST_DISP = 3'd3,
    ST_IMM  = 3'd4
  } ifp_state_e;

  function automatic logic is_short_mov(input logic [7:0] opc);
    return opc[7:3] == 5'b10111;
  endfunction

  function automatic logic [2:0] imm_bytes(input logic [1:0] code, input logic o32);
    case (code)
      IMC_NONE: return 3'd0;
      IMC_ONE:  return 3'd1;
      IMC_TWO:  return 3'd2;
      default:  return o32 ? 3'd4 : 3'd2;
    endcase
  endfunction

  function automatic logic sib_follows(input logic a32, input logic [1:0] md,
                                       input logic [2:0] rm);
    return a32 && (md != 2'b11) && (rm == 3'b100);
  endfunction

  function automatic logic [2:0] disp_bytes_mode(input logic a32, input logic [1:0] md,
                                                 input logic [2:0] rm);
    case (md)
      2'b00: begin
        if (a32) return (rm == 3'b101) ? 3'd4 : 3'd0;
        else     return (rm == 3'b110) ? 3'd2 : 3'd0;
      end
      2'b01:   return 3'd1;
      2'b10:   return a32 ? 3'd4 : 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] disp_bytes_sib(input logic [1:0] md, input logic [2:0] base);
    case (md)
      2'b00:   return (base == 3'b101) ? 3'd4 : 3'd0;
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

endpackage

// File: rtl/ifp_optable.sv
module ifp_optable
  import ifp_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic [7:0]           opcode,
  input  logic [NUM_ENT*8-1:0] match_i,
  input  logic [NUM_ENT*8-1:0] mask_i,
  input  logic [NUM_ENT-1:0]   modrm_i,
  input  logic [NUM_ENT*2-1:0] imm_i,
  output logic                 want_modrm,
  output logic [1:0]           imm_code
);

  logic [NUM_ENT-1:0] hit;

  for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
    assign hit[g] = ((opcode ^ match_i[g*8 +: 8]) & mask_i[g*8 +: 8]) == 8'h00;
  end

  // Walk from the highest entry down so the lowest matching index wins.
  always_comb begin
    want_modrm = 1'b0;
    imm_code   = IMC_NONE;
    for (int k = NUM_ENT - 1; k >= 0; k--) begin
      if (hit[k]) begin
        want_modrm = modrm_i[k];
        imm_code   = imm_i[k*2 +: 2];
      end
    end
    if (is_short_mov(opcode)) begin
      want_modrm = 1'b0;
      imm_code   = IMC_OPSZ;
    end
  end

endmodule

// File: rtl/ifp_addr_geom.sv
module ifp_addr_geom
  import ifp_pkg::*;
(
  input  logic       addr32,
  input  logic [7:0] mode_byte,
  input  logic [7:0] sib_byte,
  output logic       sib_needed,
  output logic [2:0] disp_mode,
  output logic [2:0] disp_sib
);

  logic [1:0] md;
  logic [2:0] rm;

  assign md         = mode_byte[7:6];
  assign rm         = mode_byte[2:0];
  assign sib_needed = sib_follows(addr32, md, rm);
  assign disp_mode  = disp_bytes_mode(addr32, md, rm);
  assign disp_sib   = disp_bytes_sib(md, sib_byte[2:0]);

endmodule

// File: rtl/ifp_lane_accum.sv
module ifp_lane_accum
  import ifp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               wr,
  input  logic [POS_W-1:0]   pos,
  input  logic [7:0]         din,
  output logic [FIELD_W-1:0] val,
  output logic [FIELD_W-1:0] val_nxt
);

  logic [FIELD_W-1:0] val_q;

  always_comb begin
    val_nxt = val_q;
    if (wr) val_nxt[pos*8 +: 8] = din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   val_q <= '0;
    else if (clr) val_q <= '0;
    else          val_q <= val_nxt;
  end

  assign val = val_q;

endmodule

// File: rtl/instr_field_parser.sv
module instr_field_parser
  import ifp_pkg::*;
#(
  parameter int NUM_ENT    = 8,
  parameter bit ADDR32_DEF = 1'b0,
  parameter bit OPND32_DEF = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 stall,
  input  logic                 in_valid,
  input  logic [7:0]           in_byte,
  output logic                 in_ready,
  input  logic [NUM_ENT*8-1:0] tbl_match,
  input  logic [NUM_ENT*8-1:0] tbl_mask,
  input  logic [NUM_ENT-1:0]   tbl_modrm,
  input  logic [NUM_ENT*2-1:0] tbl_imm,
  output logic                 rec_valid,
  output logic                 rec_opnd32,
  output logic                 rec_addr32,
  output logic [7:0]           rec_opcode,
  output logic                 rec_has_modrm,
  output logic [1:0]           rec_mod,
  output logic [2:0]           rec_reg,
  output logic [2:0]           rec_rm,
  output logic                 rec_has_sib,
  output logic [1:0]           rec_scale,
  output logic [2:0]           rec_index,
  output logic [2:0]           rec_base,
  output logic [2:0]           rec_disp_len,
  output logic [31:0]          rec_disp,
  output logic [2:0]           rec_imm_len,
  output logic [31:0]          rec_imm
);

  // Named events, also observed by the bound checker.
  logic evt_accept;
  logic evt_prefix;
  logic evt_emit;

  ifp_state_e       st_q, st_n;
  logic             p66_q, p66_n, p67_q, p67_n;
  logic [7:0]       opc_q, opc_n;
  logic             mrm_ok_q, mrm_ok_n;
  logic [7:0]       mrm_q, mrm_n;
  logic             sib_ok_q, sib_ok_n;
  logic [7:0]       sib_q, sib_n;
  logic [2:0]       dlen_q, dlen_n;
  logic [2:0]       ilen_q, ilen_n;
  logic [POS_W-1:0] pos_q, pos_n;

  logic a32_cur, o32_cur;
  assign a32_cur = ADDR32_DEF ^ p67_q;
  assign o32_cur = OPND32_DEF ^ p66_q;

  assign in_ready   = !stall;
  assign evt_accept = in_valid && in_ready;

  // Opcode table lookup on the byte currently offered.
  logic       tab_mrm;
  logic [1:0] tab_imm;

  ifp_optable #(.NUM_ENT(NUM_ENT)) u_tab (
    .opcode     (in_byte),
    .match_i    (tbl_match),
    .mask_i     (tbl_mask),
    .modrm_i    (tbl_modrm),
    .imm_i      (tbl_imm),
    .want_modrm (tab_mrm),
    .imm_code   (tab_imm)
  );

  // Addressing geometry: mode byte is the live byte in ST_MODE, the stored one in ST_SIB.
  logic [7:0] geo_mode;
  logic       geo_sib;
  logic [2:0] geo_dmode, geo_dsib;

  assign geo_mode = (st_q == ST_MODE) ? in_byte : mrm_q;

  ifp_addr_geom u_geom (
    .addr32     (a32_cur),
    .mode_byte  (geo_mode),
    .sib_byte   (in_byte),
    .sib_needed (geo_sib),
    .disp_mode  (geo_dmode),
    .disp_sib   (geo_dsib)
  );

  // Little-endian field assembly.
  logic [FIELD_W-1:0] disp_q, disp_n, imm_q, imm_n;

  ifp_lane_accum u_disp (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (evt_emit),
    .wr      (evt_accept && (st_q == ST_DISP)),
    .pos     (pos_q),
    .din     (in_byte),
    .val     (disp_q),
    .val_nxt (disp_n)
  );

  ifp_lane_accum u_imm (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (evt_emit),
    .wr      (evt_accept && (st_q == ST_IMM)),
    .pos     (pos_q),
    .din     (in_byte),
    .val     (imm_q),
    .val_nxt (imm_n)
  );

  logic pos_last_disp, pos_last_imm;
  assign pos_last_disp = ({1'b0, pos_q} + 3'd1) == dlen_q;
  assign pos_last_imm  = ({1'b0, pos_q} + 3'd1) == ilen_q;

  always_comb begin
    st_n       = st_q;
    p66_n      = p66_q;
    p67_n      = p67_q;
    opc_n      = opc_q;
    mrm_ok_n   = mrm_ok_q;
    mrm_n      = mrm_q;
    sib_ok_n   = sib_ok_q;
    sib_n      = sib_q;
    dlen_n     = dlen_q;
    ilen_n     = ilen_q;
    pos_n      = pos_q;
    evt_prefix = 1'b0;
    evt_emit   = 1'b0;
    if (evt_accept) begin
      case (st_q)
        ST_LEAD: begin
          if (in_byte == PFX_OPND) begin
            p66_n      = 1'b1;
            evt_prefix = 1'b1;
          end else if (in_byte == PFX_ADDR) begin
            p67_n      = 1'b1;
            evt_prefix = 1'b1;
          end else begin
            opc_n    = in_byte;
            mrm_ok_n = tab_mrm;
            ilen_n   = imm_bytes(tab_imm, o32_cur);
            if (tab_mrm)            st_n = ST_MODE;
            else if (ilen_n != 3'd0) st_n = ST_IMM;
            else                    evt_emit = 1'b1;
          end
        end
        ST_MODE: begin
          mrm_n = in_byte;
          if (geo_sib) begin
            st_n = ST_SIB;
          end else begin
            dlen_n = geo_dmode;
            if (dlen_n != 3'd0)      st_n = ST_DISP;
            else if (ilen_q != 3'd0) st_n = ST_IMM;
            else                     evt_emit = 1'b1;
          end
        end
        ST_SIB: begin
          sib_ok_n = 1'b1;
          sib_n    = in_byte;
          dlen_n   = geo_dsib;
          if (dlen_n != 3'd0)      st_n = ST_DISP;
          else if (ilen_q != 3'd0) st_n = ST_IMM;
          else                     evt_emit = 1'b1;
        end
        ST_DISP: begin
          if (pos_last_disp) begin
            pos_n = '0;
            if (ilen_q != 3'd0) st_n = ST_IMM;
            else                evt_emit = 1'b1;
          end else begin
            pos_n = pos_q + 1'b1;
          end
        end
        ST_IMM: begin
          if (pos_last_imm) begin
            pos_n    = '0;
            evt_emit = 1'b1;
          end else begin
            pos_n = pos_q + 1'b1;
          end
        end
        default: st_n = ST_LEAD;
      endcase
    end
    if (evt_emit) st_n = ST_LEAD;
  end

  // Working state: cleared once the record has been taken.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_LEAD;
      p66_q    <= 1'b0;
      p67_q    <= 1'b0;
      opc_q    <= '0;
      mrm_ok_q <= 1'b0;
      mrm_q    <= '0;
      sib_ok_q <= 1'b0;
      sib_q    <= '0;
      dlen_q   <= '0;
      ilen_q   <= '0;
      pos_q    <= '0;
    end else if (evt_emit) begin
      st_q     <= ST_LEAD;
      p66_q    <= 1'b0;
      p67_q    <= 1'b0;
      opc_q    <= '0;
      mrm_ok_q <= 1'b0;
      mrm_q    <= '0;
      sib_ok_q <= 1'b0;
      sib_q    <= '0;
      dlen_q   <= '0;
      ilen_q   <= '0;
      pos_q    <= '0;
    end else begin
      st_q     <= st_n;
      p66_q    <= p66_n;
      p67_q    <= p67_n;
      opc_q    <= opc_n;
      mrm_ok_q <= mrm_ok_n;
      mrm_q    <= mrm_n;
      sib_ok_q <= sib_ok_n;
      sib_q    <= sib_n;
      dlen_q   <= dlen_n;
      ilen_q   <= ilen_n;
      pos_q    <= pos_n;
    end
  end

  // Record register: loaded from the next-state view so the final byte is included.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid     <= 1'b0;
      rec_opnd32    <= 1'b0;
      rec_addr32    <= 1'b0;
      rec_opcode    <= '0;
      rec_has_modrm <= 1'b0;
      rec_mod       <= '0;
      rec_reg       <= '0;
      rec_rm        <= '0;
      rec_has_sib   <= 1'b0;
      rec_scale     <= '0;
      rec_index     <= '0;
      rec_base      <= '0;
      rec_disp_len  <= '0;
      rec_disp      <= '0;
      rec_imm_len   <= '0;
      rec_imm       <= '0;
    end else begin
      rec_valid <= evt_emit;
      if (evt_emit) begin
        rec_opnd32    <= OPND32_DEF ^ p66_n;
        rec_addr32    <= ADDR32_DEF ^ p67_n;
        rec_opcode    <= opc_n;
        rec_has_modrm <= mrm_ok_n;
        rec_mod       <= mrm_n[7:6];
        rec_reg       <= is_short_mov(opc_n) ? opc_n[2:0] : mrm_n[5:3];
        rec_rm        <= mrm_n[2:0];
        rec_has_sib   <= sib_ok_n;
        rec_scale     <= sib_n[7:6];
        rec_index     <= sib_n[5:3];
        rec_base      <= sib_n[2:0];
        rec_disp_len  <= dlen_n;
        rec_disp      <= disp_n;
        rec_imm_len   <= ilen_n;
        rec_imm       <= imm_n;
      end
    end
  end

endmodule

// File: rtl/ifp_checker.sv
module ifp_checker
  import ifp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       evt_accept,
  input logic       evt_prefix,
  input ifp_state_e st,
  input logic       rec_valid,
  input logic       rec_opnd32,
  input logic       rec_addr32,
  input logic [7:0] rec_opcode,
  input logic       rec_has_modrm,
  input logic [1:0] rec_mod,
  input logic [2:0] rec_rm,
  input logic       rec_has_sib,
  input logic [2:0] rec_disp_len,
  input logic [2:0] rec_imm_len
);

  AST_PREFIX_NO_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    evt_prefix |=> !rec_valid); // R2

  AST_SIB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_has_sib) |-> (rec_addr32 && rec_has_modrm && rec_mod != 2'b11 && rec_rm == 3'b100)); // R4

  AST_DISP16_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_addr32) |-> (rec_disp_len <= 3'd2)); // R5

  AST_DISP32_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_addr32) |-> (rec_disp_len == 3'd0 || rec_disp_len == 3'd1 || rec_disp_len == 3'd4)); // R6

  AST_REGFORM_NO_DISP: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_has_modrm && rec_mod == 2'b11) |-> (rec_disp_len == 3'd0 && !rec_has_sib)); // R5

  AST_SHORT_MOV_FORM: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_opcode[7:3] == 5'b10111) |-> (!rec_has_modrm && rec_imm_len == (rec_opnd32 ? 3'd4 : 3'd2))); // R9

  AST_RECORD_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(evt_accept)); // R10

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_accept |=> ($stable(st) && !rec_valid)); // R11

endmodule

bind instr_field_parser ifp_checker u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .evt_accept    (evt_accept),
  .evt_prefix    (evt_prefix),
  .st            (st_q),
  .rec_valid     (rec_valid),
  .rec_opnd32    (rec_opnd32),
  .rec_addr32    (rec_addr32),
  .rec_opcode    (rec_opcode),
  .rec_has_modrm (rec_has_modrm),
  .rec_mod       (rec_mod),
  .rec_rm        (rec_rm),
  .rec_has_sib   (rec_has_sib),
  .rec_disp_len  (rec_disp_len),
  .rec_imm_len   (rec_imm_len)
);

// File: tb/instr_field_parser_test.sv
module instr_field_parser_test;

  localparam int NE = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, stall, in_valid, in_ready;
  logic [7:0] in_byte;
  logic [NE*8-1:0] tbl_match, tbl_mask;
  logic [NE-1:0]   tbl_modrm;
  logic [NE*2-1:0] tbl_imm;
  logic rec_valid, rec_opnd32, rec_addr32, rec_has_modrm, rec_has_sib;
  logic [7:0] rec_opcode;
  logic [1:0] rec_mod, rec_scale;
  logic [2:0] rec_reg, rec_rm, rec_index, rec_base, rec_disp_len, rec_imm_len;
  logic [31:0] rec_disp, rec_imm;

  // Opcode table used by the bench (entry 7 overlaps entries 2 and 3).
  localparam logic [7:0] TM [NE] = '{8'h88, 8'h00, 8'h80, 8'h81, 8'h04, 8'h05, 8'hC2, 8'h80};
  localparam logic [7:0] TK [NE] = '{8'hFC, 8'hFC, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hE0};
  localparam logic       TR [NE] = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};
  localparam logic [1:0] TI [NE] = '{2'd0, 2'd0, 2'd1, 2'd3, 2'd1, 2'd3, 2'd2, 2'd0};

  for (genvar g = 0; g < NE; g++) begin : g_tbl
    assign tbl_match[g*8 +: 8] = TM[g];
    assign tbl_mask[g*8 +: 8]  = TK[g];
    assign tbl_modrm[g]        = TR[g];
    assign tbl_imm[g*2 +: 2]   = TI[g];
  end

  instr_field_parser uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .tbl_match(tbl_match), .tbl_mask(tbl_mask), .tbl_modrm(tbl_modrm),
    .tbl_imm(tbl_imm), .rec_valid(rec_valid), .rec_opnd32(rec_opnd32), .rec_addr32(rec_addr32),
    .rec_opcode(rec_opcode), .rec_has_modrm(rec_has_modrm), .rec_mod(rec_mod), .rec_reg(rec_reg),
    .rec_rm(rec_rm), .rec_has_sib(rec_has_sib), .rec_scale(rec_scale), .rec_index(rec_index),
    .rec_base(rec_base), .rec_disp_len(rec_disp_len), .rec_disp(rec_disp),
    .rec_imm_len(rec_imm_len), .rec_imm(rec_imm)
  );

  typedef struct {
    logic       o32, a32;
    logic [7:0] opc;
    logic       hm;
    logic [1:0] md;
    logic [2:0] rg, rm;
    logic       hs;
    logic [1:0] sc;
    logic [2:0] ix, bs;
    int         dl;
    logic [31:0] dv;
    int         il;
    logic [31:0] iv;
    logic       shortf;
  } exp_t;

  exp_t       exp_q[$];
  logic [7:0] byte_q[$];
  logic       last_q[$];

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  bit timed_out = 0;
  bit rnd = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] keep_bytes(input logic [31:0] v, input int n);
    logic [31:0] r = '0;
    for (int k = 0; k < n; k++) r[k*8 +: 8] = v[k*8 +: 8];
    return r;
  endfunction

  // Behavioural expectation of one instruction, derived from the requirements.
  task automatic add_instr(input int n66, input int n67, input logic [7:0] opc,
                           input logic [7:0] mrm, input logic [7:0] sib,
                           input logic [31:0] dv, input logic [31:0] iv);
    exp_t e;
    logic [7:0] b[$];
    int code;
    bit found;
    e = '{default: '0};
    e.o32 = (n66 > 0);
    e.a32 = (n67 > 0);
    e.opc = opc;
    for (int k = 0; k < n66; k++) b.push_back(8'h66);
    for (int k = 0; k < n67; k++) b.push_back(8'h67);
    b.push_back(opc);
    code = 0;
    found = 0;
    if (opc[7:3] == 5'b10111) begin
      e.shortf = 1;
      e.hm = 0;
      code = 3;
      e.rg = opc[2:0];
    end else begin
      for (int k = 0; k < NE; k++) begin
        if (!found && (((opc ^ TM[k]) & TK[k]) == 8'h00)) begin
          found = 1;
          e.hm = TR[k];
          code = int'(TI[k]);
        end
      end
    end
    if (code == 0) e.il = 0;
    else if (code == 1) e.il = 1;
    else if (code == 2) e.il = 2;
    else e.il = e.o32 ? 4 : 2;
    if (e.hm) begin
      b.push_back(mrm);
      e.md = mrm[7:6];
      e.rg = mrm[5:3];
      e.rm = mrm[2:0];
      if (e.md == 2'd3) begin
        e.dl = 0;
      end else if (e.a32) begin
        if (e.rm == 3'd4) begin
          b.push_back(sib);
          e.hs = 1;
          e.sc = sib[7:6];
          e.ix = sib[5:3];
          e.bs = sib[2:0];
          if (e.md == 2'd1) e.dl = 1;
          else if (e.md == 2'd2) e.dl = 4;
          else e.dl = (e.bs == 3'd5) ? 4 : 0;
        end else begin
          if (e.md == 2'd1) e.dl = 1;
          else if (e.md == 2'd2) e.dl = 4;
          else e.dl = (e.rm == 3'd5) ? 4 : 0;
        end
      end else begin
        if (e.md == 2'd1) e.dl = 1;
        else if (e.md == 2'd2) e.dl = 2;
        else e.dl = (e.rm == 3'd6) ? 2 : 0;
      end
    end
    for (int k = 0; k < e.dl; k++) b.push_back(dv[k*8 +: 8]);
    for (int k = 0; k < e.il; k++) b.push_back(iv[k*8 +: 8]);
    e.dv = keep_bytes(dv, e.dl);
    e.iv = keep_bytes(iv, e.il);
    for (int k = 0; k < b.size(); k++) begin
      byte_q.push_back(b[k]);
      last_q.push_back(k == b.size() - 1);
    end
    exp_q.push_back(e);
  endtask

  task automatic cmp_record(input exp_t e);
    string lreq;
    lreq = e.a32 ? "R6" : "R5";
    chk("R2", "opnd32", 32'(rec_opnd32), 32'(e.o32));
    chk("R2", "addr32", 32'(rec_addr32), 32'(e.a32));
    chk("R3", "opcode", 32'(rec_opcode), 32'(e.opc));
    chk(e.shortf ? "R9" : "R8", "has_modrm", 32'(rec_has_modrm), 32'(e.hm));
    chk("R3", "mod", 32'(rec_mod), 32'(e.md));
    chk(e.shortf ? "R9" : "R3", "reg", 32'(rec_reg), 32'(e.rg));
    chk("R3", "rm", 32'(rec_rm), 32'(e.rm));
    chk("R4", "has_sib", 32'(rec_has_sib), 32'(e.hs));
    chk("R4", "scale", 32'(rec_scale), 32'(e.sc));
    chk("R4", "index", 32'(rec_index), 32'(e.ix));
    chk("R4", "base", 32'(rec_base), 32'(e.bs));
    chk(lreq, "disp_len", 32'(rec_disp_len), 32'(e.dl));
    chk("R7", "disp", rec_disp, e.dv);
    chk(e.shortf ? "R9" : "R8", "imm_len", 32'(rec_imm_len), 32'(e.il));
    chk("R7", "imm", rec_imm, e.iv);
  endtask

  // Drives at the falling edge and compares the model with the outputs every clock.
  task automatic run_stream();
    bit acc, lastb;
    exp_t e;
    while ((byte_q.size() > 0 || exp_q.size() > 0) && !timed_out) begin
      if (rnd) begin
        stall    = ($urandom % 5) == 0;
        in_valid = (byte_q.size() > 0) && (($urandom % 4) != 0);
      end else begin
        stall    = 1'b0;
        in_valid = byte_q.size() > 0;
      end
      in_byte = (byte_q.size() > 0) ? byte_q[0] : 8'h00;
      acc   = in_valid && !stall;
      lastb = acc && last_q[0];
      @(negedge clk);
      cyc++;
      chk("R11", "in_ready", 32'(in_ready), 32'(!stall));
      chk("R10", "rec_valid", 32'(rec_valid), 32'(lastb));
      if (lastb) begin
        e = exp_q.pop_front();
        if (rec_valid) cmp_record(e);
      end
      if (acc) begin
        void'(byte_q.pop_front());
        void'(last_q.pop_front());
      end
      if (cyc > 150000) begin
        timed_out = 1;
        mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      end
    end
    in_valid = 1'b0;
    stall    = 1'b0;
    @(negedge clk);
    chk("R10", "rec_valid idle", 32'(rec_valid), 32'd0);
  endtask

  localparam logic [7:0] OPS [16] = '{8'h88, 8'h89, 8'h8A, 8'h8B, 8'h01, 8'h80, 8'h81, 8'h83,
                                      8'h04, 8'h05, 8'hC2, 8'h90, 8'hF4, 8'hB9, 8'hBC, 8'h03};

  initial begin
    rst_n = 1'b0; stall = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    repeat (2) @(negedge clk);
    chk("R1", "rec_valid in reset", 32'(rec_valid), 32'd0);
    chk("R1", "in_ready in reset", 32'(in_ready), 32'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "rec_valid after reset", 32'(rec_valid), 32'd0);
    stall = 1'b1;
    #1;
    chk("R1", "in_ready with stall", 32'(in_ready), 32'd0);
    stall = 1'b0;

    // Directed instructions, streamed back to back.
    add_instr(0, 0, 8'h88, 8'hC3, 8'h00, 32'h0, 32'h0);
    add_instr(0, 0, 8'h01, 8'h81, 8'h00, 32'h1234, 32'h0);
    add_instr(1, 0, 8'hB9, 8'h00, 8'h00, 32'h0, 32'h00000002);
    add_instr(0, 1, 8'h8B, 8'h04, 8'h4B, 32'h0, 32'h0);
    add_instr(0, 0, 8'h8B, 8'h46, 8'h00, 32'h00, 32'h0);
    add_instr(0, 0, 8'h8B, 8'h06, 8'h00, 32'h5678, 32'h0);
    add_instr(0, 1, 8'h8B, 8'h05, 8'h00, 32'h11223344, 32'h0);
    add_instr(0, 1, 8'h8B, 8'h44, 8'h25, 32'h10, 32'h0);
    add_instr(0, 1, 8'h8B, 8'h04, 8'h25, 32'hCAFEF00D, 32'h0);
    add_instr(0, 1, 8'h8B, 8'h84, 8'h88, 32'h89ABCDEF, 32'h0);
    add_instr(0, 1, 8'h8B, 8'h80, 8'h00, 32'h01020304, 32'h0);
    add_instr(0, 0, 8'h8B, 8'h80, 8'h00, 32'hBEEF, 32'h0);
    add_instr(0, 1, 8'h8B, 8'hC4, 8'h00, 32'h0, 32'h0);
    add_instr(0, 0, 8'h8B, 8'h04, 8'h00, 32'h0, 32'h0);
    add_instr(0, 0, 8'h80, 8'hC1, 8'h00, 32'h0, 32'h7F);
    add_instr(0, 0, 8'h81, 8'hC1, 8'h00, 32'h0, 32'hA55A);
    add_instr(1, 0, 8'h81, 8'hC1, 8'h00, 32'h0, 32'hDEADBEEF);
    add_instr(0, 0, 8'h83, 8'h00, 8'h00, 32'h0, 32'h0);
    add_instr(0, 0, 8'h04, 8'h00, 8'h00, 32'h0, 32'h12);
    add_instr(1, 0, 8'h05, 8'h00, 8'h00, 32'h0, 32'h76543210);
    add_instr(1, 0, 8'hC2, 8'h00, 8'h00, 32'h0, 32'h0810);
    add_instr(0, 0, 8'hF4, 8'h00, 8'h00, 32'h0, 32'h0);
    add_instr(2, 2, 8'hB8, 8'h00, 8'h00, 32'h0, 32'hFEDCBA98);
    add_instr(0, 0, 8'hB8, 8'h00, 8'h00, 32'h0, 32'h4321);
    add_instr(1, 1, 8'h81, 8'h84, 8'h24, 32'h0BADCAFE, 32'h13579BDF);
    run_stream();

    // Random instructions with stalls and gaps.
    rnd = 1;
    for (int n = 0; n < 400; n++) begin
      add_instr((($urandom % 3) == 0) ? 1 + int'($urandom % 2) : 0,
                (($urandom % 2) == 0) ? 1 : 0,
                OPS[$urandom % 16], 8'($urandom), 8'($urandom), $urandom, $urandom);
    end
    run_stream();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule